// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers single-cycle event pulses from a serial protocol engine into two 8-bit interrupt status registers. Each status register is paired with an 8-bit mask register. A set mask bit keeps its event from ever raising the interrupt output or showing in the global summary register. A visibility input chooses what happens to masked events. When it is low, they are dropped. When it is high, they are recorded in the status register but stay silent. Status registers are sticky and clear when they are read.

Software reaches the block through a simple synchronous bus. A write to a mask address loads that mask. A read of the same address returns the matching status register and clears it at the next clock edge. Read data is combinational and valid during the cycle in which the read strobe is high. A transmit-underrun event on status register 1 raises a transmitter lockout output. The lockout holds the transmitter and its FIFO in reset until software reads status register 1. The interrupt output is active-high and is formed from registered state only.

Top module: `isc_top`

## Requirements
- R1: After reset, both mask registers hold 0xFF, both status registers hold 0, and `irq` and `tx_lockout` are 0.
- R2: A write to address 0x3A loads mask 0 and a write to address 0x3B loads mask 1. A mask bit of 1 masks the event at that position and 0 enables it. Mask 0 bit 6 and mask 1 bits 7 and 6 always read as 1, whatever value is written.
- R3: While `show_masked` is 0, an event whose mask bit is 1 is not recorded in its status register.
- R4: While `show_masked` is 1, a masked event is recorded in its status register but does not raise `irq` or any summary bit.
- R5: A status bit set by an event stays set until its register is read, even if its mask bit changes in the meantime.
- R6: A read of address 0x3A or 0x3B returns status register 0 or 1 in the same cycle and clears that register at the clock edge. An event on that same edge is kept.
- R7: A read of address 0x38 returns the summary. Bit 0 is 1 when status 0 has any set bit whose mask bit is 0, and bit 1 is the same test for status 1. Bits 7 to 2 are 0. Reading the summary clears nothing.
- R8: `irq` is 1 exactly when some summary bit is 1.
- R9: An underrun event on `ev1[4]` sets `tx_lockout` at the next edge, whatever the mask holds. `tx_lockout` stays set until a read of address 0x3B. If an underrun arrives on that read edge, `tx_lockout` stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 8 | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, valid while `rd_en` is high, otherwise 0 |
| ev0 | input | 8 | Event pulses for status register 0 |
| ev1 | input | 8 | Event pulses for status register 1; bit 4 is the transmit underrun |
| show_masked | input | 1 | 1 records masked events, 0 drops them |
| irq | output | 1 | Interrupt request, active high |
| tx_lockout | output | 1 | Transmitter and FIFO reset-and-disable |

## Verification
The hardest cases to reach are the ones where a clearing read and a new event fall on the same edge. Two variants matter. In one, an event arrives while its status register is being read, and the new bit must survive the clear. In the other, an underrun arrives while status register 1 is being read, and the lockout must stay set. Directed cycles drive the read strobe and the event pulse together for both variants. A long random phase then mixes reads, mask writes, visibility changes and events at high density, and a behavioural model checks every cycle against the design.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int ISC_DW = 8;

    typedef struct packed {
        logic [ISC_DW-1:0] mask;
        logic [ISC_DW-1:0] stat;
    } bank_state_t;

    typedef struct packed {
        logic lock;
    } top_state_t;
endpackage

// File: rtl/isc_bank.sv
module isc_bank
    import isc_pkg::*;
#(
    parameter logic [ISC_DW-1:0] UNUSED_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [ISC_DW-1:0] wdata,
    input  logic [ISC_DW-1:0] ev,
    input  logic              show_masked,
    output logic [ISC_DW-1:0] stat,
    output logic [ISC_DW-1:0] mask,
    output logic              pending
);
    bank_state_t       st_d, st_q;
    logic [ISC_DW-1:0] rec;

    always_comb begin
        st_d = st_q;
        // masked events are only kept when visibility is on
        rec  = ev & (show_masked ? {ISC_DW{1'b1}} : ~st_q.mask);
        if (rd_hit) begin
            st_d.stat = rec;
        end else begin
            st_d.stat = st_q.stat | rec;
        end
        if (wr_hit) begin
            st_d.mask = wdata | UNUSED_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= {ISC_DW{1'b1}};
            st_q.stat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat    = st_q.stat;
    assign mask    = st_q.mask;
    assign pending = |(st_q.stat & ~st_q.mask);

    assert_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!show_masked && !rd_hit && !wr_hit) |=>
            ((stat & ~$past(stat)) & mask) == '0);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (stat & $past(stat)) == $past(stat));

    assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && ev == '0) |=> stat == '0);

    assert_unused_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (mask & UNUSED_MASK) == UNUSED_MASK);
endmodule

// File: rtl/isc_top.sv
module isc_top
    import isc_pkg::*;
#(
    parameter int          AW         = 8,
    parameter logic [AW-1:0] ADDR_REG0 = 8'h3A,
    parameter logic [AW-1:0] ADDR_REG1 = 8'h3B,
    parameter logic [AW-1:0] ADDR_SUM  = 8'h38,
    parameter int          UNDERRUN_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [ISC_DW-1:0] wdata,
    output logic [ISC_DW-1:0] rdata,
    input  logic [ISC_DW-1:0] ev0,
    input  logic [ISC_DW-1:0] ev1,
    input  logic              show_masked,
    output logic              irq,
    output logic              tx_lockout
);
    localparam int NBANK = 2;
    localparam logic [ISC_DW-1:0] UNUSED0 = 8'h40;
    localparam logic [ISC_DW-1:0] UNUSED1 = 8'hC0;

    logic [NBANK-1:0]             wr_hit, rd_hit, pending;
    logic [NBANK-1:0][ISC_DW-1:0] ev_v, stat_v, mask_v;
    logic [ISC_DW-1:0]            summary;
    top_state_t                   tp_d, tp_q;

    assign ev_v[0] = ev0;
    assign ev_v[1] = ev1;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            localparam logic [AW-1:0]     BADDR = (b == 0) ? ADDR_REG0 : ADDR_REG1;
            localparam logic [ISC_DW-1:0] BUNUS = (b == 0) ? UNUSED0 : UNUSED1;
            assign wr_hit[b] = wr_en && (addr == BADDR);
            assign rd_hit[b] = rd_en && (addr == BADDR);
            isc_bank #(.UNUSED_MASK(BUNUS)) u_bank (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_hit      (wr_hit[b]),
                .rd_hit      (rd_hit[b]),
                .wdata       (wdata),
                .ev          (ev_v[b]),
                .show_masked (show_masked),
                .stat        (stat_v[b]),
                .mask        (mask_v[b]),
                .pending     (pending[b])
            );
        end
    endgenerate

    always_comb begin
        summary = '0;
        summary[NBANK-1:0] = pending;
    end

    always_comb begin
        tp_d = tp_q;
        if (ev1[UNDERRUN_BIT]) begin
            tp_d.lock = 1'b1;
        end else if (rd_hit[1]) begin
            tp_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q.lock <= 1'b0;
        end else begin
            tp_q <= tp_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_REG0) begin
                rdata = stat_v[0];
            end else if (addr == ADDR_REG1) begin
                rdata = stat_v[1];
            end else if (addr == ADDR_SUM) begin
                rdata = summary;
            end
        end
    end

    assign irq        = |summary;
    assign tx_lockout = tp_q.lock;

    assert_lock_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev1[UNDERRUN_BIT] |=> tx_lockout);

    assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lockout && !(rd_en && addr == ADDR_REG1)) |=> tx_lockout);

    assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_v[0] & ~mask_v[0]) == '0 && (stat_v[1] & ~mask_v[1]) == '0) |-> !irq);
endmodule

// File: tb/isc_top_bench.sv
module isc_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, show_masked = 1'b0;
    logic [7:0] addr = '0, wdata = '0, ev0 = '0, ev1 = '0;
    logic [7:0] rdata;
    logic       irq, tx_lockout;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference state
    int m_mask [2];
    int m_stat [2];
    int m_lock;

    always #2.5 clk = ~clk;

    isc_top u_isc_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev0(ev0), .ev1(ev1),
        .show_masked(show_masked), .irq(irq), .tx_lockout(tx_lockout)
    );

    function automatic int model_sum();
        int s = 0;
        if ((m_stat[0] & ~m_mask[0] & 255) != 0) s |= 1;
        if ((m_stat[1] & ~m_mask[1] & 255) != 0) s |= 2;
        return s;
    endfunction

    function automatic int model_read(int a);
        if (a == 'h3A) return m_stat[0];
        if (a == 'h3B) return m_stat[1];
        if (a == 'h38) return model_sum();
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive, compare combinational outputs, clock, update model
    task automatic cyc(string tag, logic w, logic r, int a, int wd, int e0, int e1, logic vis);
        int rec [2];
        int ev [2];
        wr_en = w; rd_en = r; addr = a[7:0]; wdata = wd[7:0];
        ev0 = e0[7:0]; ev1 = e1[7:0]; show_masked = vis;
        #1;
        check(tag, int'(irq), (model_sum() != 0) ? 1 : 0, "irq");            // R8
        check(tag, int'(tx_lockout), m_lock, "tx_lockout");
        if (r) check(tag, int'(rdata), model_read(a), "rdata");
        @(posedge clk);
        ev[0] = e0 & 255; ev[1] = e1 & 255;
        for (int b = 0; b < 2; b++) begin
            rec[b] = vis ? ev[b] : (ev[b] & ~m_mask[b] & 255);
            if (r && a == ('h3A + b)) m_stat[b] = rec[b];
            else m_stat[b] = m_stat[b] | rec[b];
        end
        if (w && a == 'h3A) m_mask[0] = (wd & 255) | 'h40;
        if (w && a == 'h3B) m_mask[1] = (wd & 255) | 'hC0;
        if (ev[1] & 16) m_lock = 1;
        else if (r && a == 'h3B) m_lock = 0;
        #1;
        wr_en = 0; rd_en = 0; ev0 = 0; ev1 = 0;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_mask[0] = 255; m_mask[1] = 255; m_stat[0] = 0; m_stat[1] = 0; m_lock = 0;
        #12 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", int'(irq), 0, "irq after reset");
        check("R1", int'(tx_lockout), 0, "lockout after reset");
        cyc("R1", 0, 1, 'h38, 0, 0, 0, 0);
        cyc("R1", 0, 1, 'h3A, 0, 0, 0, 0);
        cyc("R1", 0, 1, 'h3B, 0, 0, 0, 0);
        // R3: masked events dropped when visibility off
        cyc("R3", 0, 0, 0, 0, 'hFF, 'hEF, 0);
        cyc("R3", 0, 1, 'h3A, 0, 0, 0, 0);
        cyc("R3", 0, 1, 'h3B, 0, 0, 0, 0);
        // R4: masked events recorded but silent with visibility on
        cyc("R4", 0, 0, 0, 0, 'h81, 'h03, 1);
        cyc("R4", 0, 1, 'h38, 0, 0, 0, 1);
        cyc("R4", 0, 1, 'h3A, 0, 0, 0, 1);
        cyc("R4", 0, 1, 'h3B, 0, 0, 0, 1);
        // R2: mask write, unused bit 6 of mask 0 stays 1
        cyc("R2", 1, 0, 'h3A, 'h00, 0, 0, 0);
        cyc("R2", 0, 0, 0, 0, 'h41, 0, 0);
        cyc("R7", 0, 1, 'h38, 0, 0, 0, 0);
        cyc("R2", 0, 1, 'h3A, 0, 0, 0, 0);
        // R5: sticky across mask change
        cyc("R5", 0, 0, 0, 0, 'h02, 0, 0);
        cyc("R5", 1, 0, 'h3A, 'hFF, 0, 0, 0);
        cyc("R5", 0, 1, 'h38, 0, 0, 0, 0);
        cyc("R5", 1, 0, 'h3A, 'h00, 0, 0, 0);
        cyc("R5", 0, 1, 'h3A, 0, 0, 0, 0);
        // R6: read-clear with an event on the same edge
        cyc("R6", 0, 0, 0, 0, 'h10, 0, 0);
        cyc("R6", 0, 1, 'h3A, 0, 'h04, 0, 0);
        cyc("R6", 0, 1, 'h3A, 0, 0, 0, 0);
        cyc("R6", 0, 1, 'h3A, 0, 0, 0, 0);
        // R9: underrun lockout, mask 1 still all ones
        cyc("R9", 0, 0, 0, 0, 0, 'h10, 0);
        cyc("R9", 0, 1, 'h3A, 0, 0, 0, 0);
        cyc("R9", 0, 1, 'h38, 0, 0, 0, 0);
        cyc("R9", 0, 1, 'h3B, 0, 0, 'h10, 0);
        cyc("R9", 0, 1, 'h3B, 0, 0, 0, 0);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0);
        // R2/R7: mask 1 enabled, unused bits 7:6 stay masked
        cyc("R2", 1, 0, 'h3B, 'h00, 0, 0, 0);
        cyc("R2", 0, 0, 0, 0, 0, 'hC0, 0);
        cyc("R7", 0, 1, 'h38, 0, 0, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 'h10, 0);
        cyc("R7", 0, 1, 'h38, 0, 0, 0, 0);
        cyc("R9", 0, 1, 'h3B, 0, 0, 0, 0);
        // mixed random phase, all requirements
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            int a = (sel < 4) ? 'h3A + ($urandom_range(0, 1)) : ((sel < 6) ? 'h38 : 'h3A + $urandom_range(0, 1));
            logic w = (sel >= 6 && sel < 8);
            logic r = (sel < 6);
            cyc("R6", w, r, a, $urandom_range(0, 255),
                ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : 0,
                ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : 0,
                logic'($urandom_range(0, 1)));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule